// File: doc/BRIEF.md
# Dual-Channel Disk Adapter Host Decoder

This block sits between a byte-wide memory-mapped host bus and the two disk channels of an adapter card. It splits the bus into two regions. The control region is always reachable. It holds a select register and a 4-bit board identification value that software reads bit by bit. The device region holds, for each channel, the task-file registers, the device control register, an interrupt mask location and an interrupt status location. The device region only responds while the open bit of the select register is set.

Each channel has an interrupt enable that is changed by the type of access alone. Any write to the channel's mask location sets the enable, and any read of that location clears it. The drive interrupt inputs pass through a two-flop synchronizer. They are then gated by their enables and merged into one card interrupt line. The drives themselves appear only as chip-select strobes, a register index, a write flag and a data byte in each direction.

Each bus access is run by a three-state machine:
- `ST_IDLE`: waits for `bus_req`.
- `ST_STROBE`: drives the strobes for one cycle and applies the side effects.
- `ST_DONE`: returns `bus_ack` with read data for one cycle.

The transitions are IDLE→STROBE on a request, STROBE→DONE unconditionally and DONE→IDLE unconditionally. A request that arrives outside IDLE is dropped.

Top module: `ide_dual_card_if`

## Requirements
- R1: After reset the select register reads 0, both interrupt enables are clear, `card_irq`, `dma_chan`, `bus_ack`, `tf_cs` and `ctl_cs` are all 0.
- R2: A control-region read at offset 0x2280 + 4·k (k = 0..3) returns bit k of the board value 3 in data bit 0, with bits 7..1 zero, so the four reads give 1, 1, 0, 0.
- R3: A control-region write at offset 0 stores the byte in the select register. A read there returns the byte. Bit 0 of the register drives `dma_chan`.
- R4: While select bit 5 is 0, a device-region access asserts no strobe, reads as 0 and leaves both interrupt enables unchanged.
- R5: With select bit 5 set, a device-region access at 0x2000 + 64·n (channel 0) or 0x3000 + 64·n (channel 1), n = 0..7, asserts `tf_cs[ch]` for exactly the strobe cycle. During that cycle `dev_reg` is n, `dev_wr` is 1 for a write, and `dev_wdata` carries the write byte. A read returns the `dev_rdata` present during the strobe cycle.
- R6: Device-region offsets 0x2380 and 0x3380 assert `ctl_cs[0]` and `ctl_cs[1]` respectively, with `tf_cs` held at 0.
- R7: Any write to 0x2200 (channel 0) or 0x3200 (channel 1) sets that channel's enable whatever the data. Any read there clears the enable and returns 0. The two enables do not affect each other.
- R8: Bit 0 of a read at 0x2290 or 0x3290 returns the synchronized interrupt of channel 0 or 1, whether the channel is enabled or not. Bits 7..1 read 0.
- R9: `card_irq` is the OR over both channels of the synchronized interrupt ANDed with the enable. A drive interrupt change reaches `card_irq` on the second rising edge after it is applied.
- R10: Reads of unmapped offsets return 0 and assert no strobe. This covers unaligned task-file offsets, gaps inside a channel window, addresses outside both windows and unused control-region offsets.
- R11: A request taken in idle gives a one-cycle strobe phase and then a one-cycle `bus_ack`. A request raised while an access is in flight is ignored.
- R12: Writing 0 to the select register closes the device region again and sends `dma_chan` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access request, sampled in idle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_fast | input | 1 | Region: 0 = control, 1 = device |
| bus_addr | input | 14 | Byte offset inside the region |
| bus_wdata | input | 8 | Write data |
| bus_ack | output | 1 | One-cycle access completion |
| bus_rdata | output | 8 | Read data, valid with `bus_ack` |
| tf_cs | output | 2 | Task-file chip select per channel |
| ctl_cs | output | 2 | Device control chip select per channel |
| dev_reg | output | 3 | Task-file register index |
| dev_wr | output | 1 | Direction of the strobed access |
| dev_wdata | output | 8 | Byte written to the drive |
| dev_rdata | input | 8 | Byte read from the drive |
| drv_irq | input | 2 | Drive interrupt per channel, asynchronous |
| card_irq | output | 1 | Combined card interrupt |
| dma_chan | output | 1 | Channel that receives the DMA request and acknowledge |

## Verification
A wrong interrupt enable appears on `card_irq` in the ack cycle of the mask access that set or cleared it, provided the channel's drive interrupt is held high. The bench therefore keeps the interrupts asserted while it toggles the enables. A stuck or wrong select register shows on `dma_chan` and on the presence of device-region strobes in the very next access. A fault in the access state machine shows as strobes or an ack in the wrong cycle, or as a dropped or duplicated access, within two cycles of the request. A broken synchronizer shows as a `card_irq` change one edge early or late.

// File: rtl/ide_card_pkg.sv
package ide_card_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STROBE = 2'd1,
        ST_DONE   = 2'd2
    } acc_state_t;

    typedef enum logic [2:0] {
        TGT_NONE     = 3'd0,
        TGT_SELECT   = 3'd1,
        TGT_IDENT    = 3'd2,
        TGT_TASKFILE = 3'd3,
        TGT_DEVCTL   = 3'd4,
        TGT_IRQMASK  = 3'd5,
        TGT_IRQSTAT  = 3'd6
    } target_t;

endpackage

// File: rtl/ide_card_access_fsm.sv
module ide_card_access_fsm
    import ide_card_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic              bus_fast,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              in_strobe,
    output logic              in_done,
    output logic              cap_we,
    output logic              cap_fast,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [DATA_W-1:0] cap_wdata
);

    acc_state_t state_q, state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (bus_req) state_d = ST_STROBE;
            ST_STROBE: state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register and access capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cap_we    <= 1'b0;
            cap_fast  <= 1'b0;
            cap_addr  <= '0;
            cap_wdata <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && bus_req) begin
                cap_we    <= bus_we;
                cap_fast  <= bus_fast;
                cap_addr  <= bus_addr;
                cap_wdata <= bus_wdata;
            end
        end
    end

    // outputs
    always_comb begin
        in_strobe = 1'b0;
        in_done   = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_STROBE: in_strobe = 1'b1;
            ST_DONE:   in_done   = 1'b1;
            default:   ;
        endcase
    end

    // R11: the ack lasts a single cycle
    assert_ack_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_done |=> !in_done);

    // R11: a strobe phase is always followed by the ack
    assert_strobe_then_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_strobe |=> in_done);

endmodule

// File: rtl/ide_card_decode.sv
module ide_card_decode
    import ide_card_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int NUM_CH    = 2,
    parameter int CH_W      = 1,
    parameter int STEP      = 6,
    parameter int TF_REGS   = 8,
    parameter int IDX_W     = 3,
    parameter int CH_BASE0  = 'h2000,
    parameter int CH_STRIDE = 'h1000,
    parameter int CTL_OFF   = 'h380,
    parameter int MASK_OFF  = 'h200,
    parameter int STAT_OFF  = 'h290,
    parameter int ID_BASE   = 'h2280,
    parameter int ID_BITS   = 4,
    parameter int ID_IDX_W  = 2
) (
    input  logic                fast,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                dev_open,
    output target_t             tgt,
    output logic [CH_W-1:0]     ch_idx,
    output logic [IDX_W-1:0]    tf_idx,
    output logic [ID_IDX_W-1:0] id_idx
);

    localparam logic [ADDR_W-1:0] TF_SPAN = ADDR_W'(TF_REGS << STEP);
    localparam logic [ADDR_W-1:0] ID_AT   = ADDR_W'(ID_BASE);
    localparam logic [ADDR_W-1:0] ID_SPAN = ADDR_W'(ID_BITS * 4);
    localparam logic [ADDR_W-1:0] WIN     = ADDR_W'(CH_STRIDE);

    logic [NUM_CH-1:0] tf_hit, ctl_hit, mask_hit, stat_hit;
    logic [IDX_W-1:0]  ch_tf_idx [NUM_CH];

    // per-channel window decode
    for (genvar c = 0; c < NUM_CH; c++) begin : g_win
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(CH_BASE0 + c * CH_STRIDE);
        logic [ADDR_W-1:0] off;
        logic              in_win;
        assign off           = addr - BASE;
        assign in_win        = (addr >= BASE) && (off < WIN);
        assign tf_hit[c]     = in_win && (off < TF_SPAN) && (off[STEP-1:0] == '0);
        assign ctl_hit[c]    = in_win && (off == ADDR_W'(CTL_OFF));
        assign mask_hit[c]   = in_win && (off == ADDR_W'(MASK_OFF));
        assign stat_hit[c]   = in_win && (off == ADDR_W'(STAT_OFF));
        assign ch_tf_idx[c]  = off[STEP +: IDX_W];
    end

    // board identification bits in the control region
    logic [ADDR_W-1:0] id_off;
    logic              id_hit;
    assign id_off = addr - ID_AT;
    assign id_hit = (addr >= ID_AT) && (id_off < ID_SPAN) && (id_off[1:0] == 2'b00);
    assign id_idx = id_off[2 +: ID_IDX_W];

    always_comb begin
        tgt    = TGT_NONE;
        ch_idx = '0;
        tf_idx = '0;
        if (!fast) begin
            if (addr == '0)  tgt = TGT_SELECT;
            else if (id_hit) tgt = TGT_IDENT;
        end else if (dev_open) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (tgt == TGT_NONE) begin
                    if (tf_hit[c]) begin
                        tgt    = TGT_TASKFILE;
                        ch_idx = CH_W'(c);
                        tf_idx = ch_tf_idx[c];
                    end else if (ctl_hit[c]) begin
                        tgt    = TGT_DEVCTL;
                        ch_idx = CH_W'(c);
                    end else if (mask_hit[c]) begin
                        tgt    = TGT_IRQMASK;
                        ch_idx = CH_W'(c);
                    end else if (stat_hit[c]) begin
                        tgt    = TGT_IRQSTAT;
                        ch_idx = CH_W'(c);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/ide_card_irq_ctl.sv
module ide_card_irq_ctl #(
    parameter int NUM_CH      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] drv_irq,
    input  logic [NUM_CH-1:0] set_en,
    input  logic [NUM_CH-1:0] clr_en,
    output logic [NUM_CH-1:0] pend,
    output logic [NUM_CH-1:0] en,
    output logic              card_irq
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        logic [SYNC_STAGES-1:0] sync_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[SYNC_STAGES-2:0], drv_irq[c]};
        end
        assign pend[c] = sync_q[SYNC_STAGES-1];

        // a read clears; a write sets; both cannot occur in one access
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         en[c] <= 1'b0;
            else if (clr_en[c]) en[c] <= 1'b0;
            else if (set_en[c]) en[c] <= 1'b1;
        end

        // R7: a read of the mask location leaves the enable clear
        assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
            clr_en[c] |=> !en[c]);

        // R7: with no mask access the enable keeps its value
        assert_enable_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !(set_en[c] || clr_en[c]) |=> $stable(en[c]));
    end

    assign card_irq = |(pend & en);

    if (SYNC_STAGES == 2) begin : g_lat_chk
        // R9: the card line is driven only by interrupts applied two edges earlier
        assert_irq_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
            card_irq |-> |(en & $past(drv_irq, 2)));
    end

endmodule

// File: rtl/ide_dual_card_if.sv
module ide_dual_card_if
    import ide_card_pkg::*;
#(
    parameter int ADDR_W      = 14,
    parameter int DATA_W      = 8,
    parameter int NUM_CH      = 2,
    parameter int STEP        = 6,
    parameter int TF_REGS     = 8,
    parameter int CH_BASE0    = 'h2000,
    parameter int CH_STRIDE   = 'h1000,
    parameter int CTL_OFF     = 'h380,
    parameter int MASK_OFF    = 'h200,
    parameter int STAT_OFF    = 'h290,
    parameter int ID_BASE     = 'h2280,
    parameter int ID_BITS     = 4,
    parameter int BOARD_ID    = 3,
    parameter int OPEN_BIT    = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_req,
    input  logic                       bus_we,
    input  logic                       bus_fast,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic                       bus_ack,
    output logic [DATA_W-1:0]          bus_rdata,
    output logic [NUM_CH-1:0]          tf_cs,
    output logic [NUM_CH-1:0]          ctl_cs,
    output logic [$clog2(TF_REGS)-1:0] dev_reg,
    output logic                       dev_wr,
    output logic [DATA_W-1:0]          dev_wdata,
    input  logic [DATA_W-1:0]          dev_rdata,
    input  logic [NUM_CH-1:0]          drv_irq,
    output logic                       card_irq,
    output logic                       dma_chan
);

    localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int IDX_W    = $clog2(TF_REGS);
    localparam int ID_IDX_W = $clog2(ID_BITS);
    localparam logic [ID_BITS-1:0] BOARD_VAL = ID_BITS'(BOARD_ID);

    logic              in_strobe, in_done, cap_we, cap_fast;
    logic [ADDR_W-1:0] cap_addr;
    logic [DATA_W-1:0] cap_wdata;
    logic [DATA_W-1:0] sel_q, rd_val, rdata_q;
    target_t           tgt;
    logic [CH_W-1:0]     ch_idx;
    logic [IDX_W-1:0]    tf_idx;
    logic [ID_IDX_W-1:0] id_idx;
    logic [NUM_CH-1:0]   set_en, clr_en, pend, en;

    ide_card_access_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_fast  (bus_fast),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .in_strobe (in_strobe),
        .in_done   (in_done),
        .cap_we    (cap_we),
        .cap_fast  (cap_fast),
        .cap_addr  (cap_addr),
        .cap_wdata (cap_wdata)
    );

    ide_card_decode #(
        .ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .CH_W(CH_W), .STEP(STEP),
        .TF_REGS(TF_REGS), .IDX_W(IDX_W), .CH_BASE0(CH_BASE0),
        .CH_STRIDE(CH_STRIDE), .CTL_OFF(CTL_OFF), .MASK_OFF(MASK_OFF),
        .STAT_OFF(STAT_OFF), .ID_BASE(ID_BASE), .ID_BITS(ID_BITS),
        .ID_IDX_W(ID_IDX_W)
    ) u_dec (
        .fast     (cap_fast),
        .addr     (cap_addr),
        .dev_open (sel_q[OPEN_BIT]),
        .tgt      (tgt),
        .ch_idx   (ch_idx),
        .tf_idx   (tf_idx),
        .id_idx   (id_idx)
    );

    ide_card_irq_ctl #(.NUM_CH(NUM_CH), .SYNC_STAGES(SYNC_STAGES)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .drv_irq  (drv_irq),
        .set_en   (set_en),
        .clr_en   (clr_en),
        .pend     (pend),
        .en       (en),
        .card_irq (card_irq)
    );

    // per-channel strobes and enable requests
    for (genvar c = 0; c < NUM_CH; c++) begin : g_strobe
        logic mine;
        assign mine      = in_strobe && (ch_idx == CH_W'(c));
        assign tf_cs[c]  = mine && (tgt == TGT_TASKFILE);
        assign ctl_cs[c] = mine && (tgt == TGT_DEVCTL);
        assign set_en[c] = mine && (tgt == TGT_IRQMASK) && cap_we;
        assign clr_en[c] = mine && (tgt == TGT_IRQMASK) && !cap_we;
    end

    assign dev_reg   = in_strobe ? tf_idx    : '0;
    assign dev_wr    = in_strobe && cap_we;
    assign dev_wdata = in_strobe ? cap_wdata : '0;

    // select register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   sel_q <= '0;
        else if (in_strobe && cap_we && tgt == TGT_SELECT) sel_q <= cap_wdata;
    end
    assign dma_chan = sel_q[0];

    // read data selection
    always_comb begin
        rd_val = '0;
        unique case (tgt)
            TGT_SELECT:   rd_val = sel_q;
            TGT_IDENT:    rd_val = DATA_W'(BOARD_VAL[id_idx]);
            TGT_TASKFILE: rd_val = dev_rdata;
            TGT_DEVCTL:   rd_val = dev_rdata;
            TGT_IRQSTAT:  rd_val = DATA_W'(pend[ch_idx]);
            default:      rd_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         rdata_q <= '0;
        else if (in_strobe) rdata_q <= cap_we ? '0 : rd_val;
    end

    assign bus_rdata = rdata_q;
    assign bus_ack   = in_done;

    // R5/R6: at most one drive strobe at a time
    assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tf_cs, ctl_cs}));

    // R4: a closed device region yields no drive strobe
    assert_closed_region_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_q[OPEN_BIT] |-> ({tf_cs, ctl_cs} == '0));

    // R11: strobes appear only between request and ack
    assert_strobe_window_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (|{tf_cs, ctl_cs}) |=> bus_ack);

endmodule

// File: tb/ide_dual_card_if_tb.sv
module ide_dual_card_if_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0, bus_fast = 1'b0;
    logic [13:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0, dev_rdata = '0;
    logic [1:0]  drv_irq = '0;
    logic        bus_ack, dev_wr, card_irq, dma_chan;
    logic [7:0]  bus_rdata, dev_wdata;
    logic [1:0]  tf_cs, ctl_cs;
    logic [2:0]  dev_reg;

    int n_checks = 0;
    int n_err = 0;
    bit finished = 0;

    // results of the last access
    logic [1:0] s_tf, s_ctl;
    logic [2:0] s_reg;
    logic       s_dwr, s_ack_early, s_ack, s_ack_late, s_irq;
    logic [7:0] s_dwd, s_rd;

    always #10 clk = ~clk;

    ide_dual_card_if dut_i (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_fast(bus_fast), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .tf_cs(tf_cs),
        .ctl_cs(ctl_cs), .dev_reg(dev_reg), .dev_wr(dev_wr),
        .dev_wdata(dev_wdata), .dev_rdata(dev_rdata), .drv_irq(drv_irq),
        .card_irq(card_irq), .dma_chan(dma_chan)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic fast, input logic [13:0] a, input logic we, input logic [7:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_fast = fast; bus_addr = a; bus_we = we; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0;
        s_tf = tf_cs; s_ctl = ctl_cs; s_reg = dev_reg; s_dwr = dev_wr;
        s_dwd = dev_wdata; s_ack_early = bus_ack;
        @(negedge clk);
        s_ack = bus_ack; s_rd = bus_rdata; s_irq = card_irq;
        @(negedge clk);
        s_ack_late = bus_ack;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1", "card_irq", card_irq, 0);
        chk("R1", "dma_chan", dma_chan, 0);
        chk("R1", "bus_ack", bus_ack, 0);
        chk("R1", "strobes", {tf_cs, ctl_cs}, 0);
        access(1'b0, 14'h0000, 1'b0, 8'h00);
        chk("R1", "select after reset", s_rd, 0);
    endtask

    task automatic t_board_id;
        for (int k = 0; k < 4; k++) begin
            access(1'b0, 14'h2280 + 14'(4 * k), 1'b0, 8'h00);
            chk("R2", $sformatf("ident bit %0d", k), s_rd, (3 >> k) & 1);
        end
    endtask

    task automatic t_gate;
        drv_irq = 2'b01;
        dev_rdata = 8'hA5;
        wait_cycles(3);
        access(1'b1, 14'h2000, 1'b0, 8'h00);
        chk("R4", "closed tf strobe", s_tf, 0);
        chk("R4", "closed read data", s_rd, 0);
        access(1'b1, 14'h2200, 1'b1, 8'h00);
        chk("R4", "closed mask write irq", s_irq, 0);
        wait_cycles(2);
        chk("R4", "closed mask write irq later", card_irq, 0);
    endtask

    task automatic t_select;
        access(1'b0, 14'h0000, 1'b1, 8'h21);
        chk("R3", "dma_chan after 0x21", dma_chan, 1);
        access(1'b0, 14'h0000, 1'b0, 8'h00);
        chk("R3", "select readback", s_rd, 8'h21);
        access(1'b0, 14'h0000, 1'b1, 8'h20);
        chk("R3", "dma_chan after 0x20", dma_chan, 0);
    endtask

    task automatic t_taskfile;
        int idx[3] = '{0, 3, 7};
        for (int ch = 0; ch < 2; ch++) begin
            for (int i = 0; i < 3; i++) begin
                logic [13:0] a;
                a = 14'h2000 + 14'(ch * 'h1000) + 14'(64 * idx[i]);
                access(1'b1, a, 1'b1, 8'h40 + 8'(idx[i]));
                chk("R5", "write tf_cs", s_tf, 1 << ch);
                chk("R5", "write dev_reg", s_reg, idx[i]);
                chk("R5", "write dev_wr", s_dwr, 1);
                chk("R5", "write dev_wdata", s_dwd, 8'h40 + idx[i]);
                dev_rdata = 8'h5A + 8'(idx[i] + ch);
                access(1'b1, a, 1'b0, 8'h00);
                chk("R5", "read tf_cs", s_tf, 1 << ch);
                chk("R5", "read dev_wr", s_dwr, 0);
                chk("R5", "read data", s_rd, 8'h5A + idx[i] + ch);
            end
        end
    endtask

    task automatic t_control;
        dev_rdata = 8'hC3;
        access(1'b1, 14'h2380, 1'b0, 8'h00);
        chk("R6", "ch0 ctl_cs", s_ctl, 2'b01);
        chk("R6", "ch0 tf_cs", s_tf, 0);
        chk("R6", "ch0 ctl read", s_rd, 8'hC3);
        access(1'b1, 14'h3380, 1'b1, 8'h0E);
        chk("R6", "ch1 ctl_cs", s_ctl, 2'b10);
        chk("R6", "ch1 tf_cs", s_tf, 0);
    endtask

    task automatic t_irq_enable;
        // drv_irq[0] is already high and synchronized
        access(1'b1, 14'h2200, 1'b1, 8'h00);
        chk("R7", "ch0 enable by write of 0", s_irq, 1);
        access(1'b1, 14'h3200, 1'b1, 8'hFF);
        chk("R7", "ch1 enable keeps ch0", s_irq, 1);
        access(1'b1, 14'h2200, 1'b0, 8'h00);
        chk("R7", "mask read data", s_rd, 0);
        chk("R7", "ch0 cleared by read", s_irq, 0);
        // R9 latency with ch1 enabled
        @(negedge clk);
        drv_irq[1] = 1'b1;
        @(negedge clk);
        chk("R9", "card_irq after one edge", card_irq, 0);
        @(negedge clk);
        chk("R9", "card_irq after two edges", card_irq, 1);
        access(1'b1, 14'h3200, 1'b0, 8'h00);
        chk("R7", "ch1 cleared by read", s_irq, 0);
        access(1'b1, 14'h2200, 1'b1, 8'h00);
        chk("R9", "ch0 alone drives line", s_irq, 1);
        access(1'b1, 14'h2200, 1'b0, 8'h00);
        chk("R9", "line low with both disabled", s_irq, 0);
    endtask

    task automatic t_status;
        drv_irq = 2'b11;
        wait_cycles(3);
        access(1'b1, 14'h2290, 1'b0, 8'h00);
        chk("R8", "ch0 status while disabled", s_rd, 1);
        access(1'b1, 14'h3290, 1'b0, 8'h00);
        chk("R8", "ch1 status while disabled", s_rd, 1);
        drv_irq = 2'b10;
        wait_cycles(3);
        access(1'b1, 14'h2290, 1'b0, 8'h00);
        chk("R8", "ch0 status low", s_rd, 0);
        access(1'b1, 14'h3290, 1'b0, 8'h00);
        chk("R8", "ch1 status still high", s_rd, 1);
    endtask

    task automatic t_unmapped;
        logic [13:0] fast_list[4] = '{14'h2004, 14'h1000, 14'h2240, 14'h3FF0};
        dev_rdata = 8'hFF;
        for (int i = 0; i < 4; i++) begin
            access(1'b1, fast_list[i], 1'b0, 8'h00);
            chk("R10", $sformatf("device 0x%0h data", fast_list[i]), s_rd, 0);
            chk("R10", $sformatf("device 0x%0h strobes", fast_list[i]), {s_tf, s_ctl}, 0);
        end
        access(1'b0, 14'h0010, 1'b0, 8'h00);
        chk("R10", "control 0x10 data", s_rd, 0);
        access(1'b0, 14'h2290, 1'b0, 8'h00);
        chk("R10", "control 0x2290 data", s_rd, 0);
    endtask

    task automatic t_busy;
        // a request raised during the strobe phase must be dropped
        @(negedge clk);
        bus_req = 1'b1; bus_fast = 1'b0; bus_addr = 14'h0000; bus_we = 1'b1; bus_wdata = 8'h20;
        @(negedge clk);
        chk("R11", "no ack in strobe phase", bus_ack, 0);
        bus_wdata = 8'h21;
        @(negedge clk);
        chk("R11", "ack after strobe", bus_ack, 1);
        bus_req = 1'b0;
        @(negedge clk);
        chk("R11", "ack single cycle", bus_ack, 0);
        chk("R11", "busy request dropped", dma_chan, 0);
        access(1'b0, 14'h0000, 1'b0, 8'h00);
        chk("R11", "select unchanged", s_rd, 8'h20);
        chk("R11", "handshake early/late", {s_ack_early, s_ack_late}, 0);
    endtask

    task automatic t_select_clear;
        access(1'b0, 14'h0000, 1'b1, 8'h21);
        access(1'b0, 14'h0000, 1'b1, 8'h00);
        chk("R12", "dma_chan after clear", dma_chan, 0);
        dev_rdata = 8'h77;
        access(1'b1, 14'h3000, 1'b0, 8'h00);
        chk("R12", "tf closed after clear", s_tf, 0);
        chk("R12", "read zero after clear", s_rd, 0);
    endtask

    initial begin
        wait_cycles(3);
        rst_n = 1'b1;
        wait_cycles(2);
        t_reset();
        t_board_id();
        t_gate();
        t_select();
        t_taskfile();
        t_control();
        t_irq_enable();
        t_status();
        t_unmapped();
        t_busy();
        t_select_clear();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

endmodule